// File: doc/BRIEF.md
# Sectored Write-Back Cache Controller

This block is a small direct-mapped data cache that sits between a CPU-side request port and a next-level memory port. Each line carries one address tag, but its storage is cut into subblocks of one data word, and every subblock keeps its own valid flag and its own modified flag. The memory port moves exactly one subblock per transfer. The controller only fetches the subblock a request needs. It fetches nothing when a write fills a whole subblock. On replacement it writes back only the modified subblocks of the old line.

Writes are write-back and write-allocate. A store changes only the cache and marks the subblock modified. Memory sees the data once, when the line is replaced, however many stores hit it before that. The CPU port is a valid/ready handshake with a one-cycle response pulse. Ready is high only while the controller is idle.

The state machine has four states. IDLE accepts a request (IDLE→LOOKUP on `cpu_valid`). LOOKUP compares the tag and subblock flags. From LOOKUP it can end the access with a response (LOOKUP→IDLE on hit or full-subblock write), start a replacement (LOOKUP→WBACK when the tag differs and modified subblocks remain), install the new tag in place (LOOKUP→LOOKUP when the tag differs and the line is clean), or fetch the one missing subblock (LOOKUP→FILL). WBACK writes modified subblocks out, lowest index first, and returns once none is left (WBACK→LOOKUP). FILL reads one subblock and returns on the memory acknowledge (FILL→LOOKUP).

Top module: `sect_wb_cache`

## Requirements
- R1: A read of a valid subblock whose line tag matches returns the stored word one cycle after lookup, with no memory transfer; a modified subblock is always also valid.
- R2: A write with all four byte enables set to an invalid subblock completes without any memory read, and the written word is then readable.
- R3: A read miss issues exactly one memory read, addressed to the requested subblock only; the memory request holds its address until acknowledged.
- R4: Writes change only the cache; no memory write happens until the line is replaced.
- R5: A write miss to an empty line allocates the line and performs the write, so a following read of that address hits.
- R6: Several writes to one subblock before replacement produce a single memory write carrying the last value.
- R7: Replacement writes back only modified subblocks, each once, and memory writes occur only when the old tag differs from the requested one.
- R8: A tag match with the requested subblock invalid fetches only that subblock into the existing line; the line's other valid subblocks are kept.
- R9: A partial write to an invalid subblock first reads that subblock from memory, then merges the enabled bytes (byte enable bit k covers data bits 8k+7..8k).
- R10: Installing a new tag clears every valid and modified flag of the line, and only after all modified subblocks are written back.
- R11: `cpu_ready` is low whenever a memory transfer is in progress, and `cpu_resp` is a single-cycle pulse per accepted request.
- R12: After reset `cpu_ready` is high, `mem_req` and `cpu_resp` are low and every subblock is invalid, so earlier modified data is not written back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | CPU request present |
| cpu_ready | output | 1 | Controller can accept a request |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W (10) | Word address: bits 1:0 subblock, 3:2 set, 9:4 tag |
| cpu_be | input | DATA_W/8 (4) | Byte enables for writes |
| cpu_wdata | input | DATA_W (32) | Write data |
| cpu_resp | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W (32) | Read data, valid with `cpu_resp` on reads |
| mem_req | output | 1 | Memory transfer request, held until `mem_ack` |
| mem_we | output | 1 | 1 = write one subblock, 0 = read one subblock |
| mem_addr | output | ADDR_W (10) | Word address of the subblock |
| mem_wdata | output | DATA_W (32) | Write-back data |
| mem_ack | input | 1 | Transfer done; read data valid this cycle |
| mem_rdata | input | DATA_W (32) | Read data from memory |

## Verification
Two things can fall in the same cycle. The acknowledge of the last modified subblock's write-back clears its modified flag. In that same cycle the controller decides whether the line may take the new tag. If the flag clearing and the tag installation were misordered, either a modified word would be lost or the fetch would go out under the old tag. This is provoked by stores to two subblocks of one line followed by a read that maps to the same set with a different tag. It is judged by the number of memory reads and writes during that access, by the word returned, and by the memory contents afterwards, all compared against values worked out from the requirements.

// File: rtl/sc_pkg.sv
package sc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOOKUP = 2'd1,
        ST_WBACK  = 2'd2,
        ST_FILL   = 2'd3
    } sc_state_e;
endpackage

// File: rtl/sc_meta.sv
// Tag plus per-subblock valid / modified flags for every set.
module sc_meta #(
    parameter int SET_BITS = 2,
    parameter int SUB_BITS = 2,
    parameter int TAG_W    = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SET_BITS-1:0] set_i,
    input  logic [SUB_BITS-1:0] sub_i,
    input  logic                alloc_i,
    input  logic [TAG_W-1:0]    new_tag_i,
    input  logic                set_valid_i,
    input  logic                set_dirty_i,
    input  logic                clr_dirty_i,
    output logic [TAG_W-1:0]    tag_o,
    output logic [(1<<SUB_BITS)-1:0] valid_o,
    output logic [(1<<SUB_BITS)-1:0] dirty_o
);
    localparam int SETS = 1 << SET_BITS;
    localparam int SUBS = 1 << SUB_BITS;

    logic [TAG_W-1:0] tag_q [SETS];
    logic [SUBS-1:0]  val_q [SETS];
    logic [SUBS-1:0]  drt_q [SETS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                tag_q[s] <= '0;
                val_q[s] <= '0;
                drt_q[s] <= '0;
            end
        end else if (alloc_i) begin
            tag_q[set_i] <= new_tag_i;
            val_q[set_i] <= '0;
            drt_q[set_i] <= '0;
        end else begin
            if (set_valid_i) val_q[set_i][sub_i] <= 1'b1;
            if (set_dirty_i) drt_q[set_i][sub_i] <= 1'b1;
            if (clr_dirty_i) drt_q[set_i][sub_i] <= 1'b0;
        end
    end

    assign tag_o   = tag_q[set_i];
    assign valid_o = val_q[set_i];
    assign dirty_o = drt_q[set_i];

    AST_ALLOC_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_i |-> (drt_q[set_i] == '0)); // R10
    AST_DIRTY_IN_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (drt_q[set_i] & ~val_q[set_i]) == '0); // R1
endmodule

// File: rtl/sc_data.sv
// Word storage, one entry per subblock, byte-enabled writes.
module sc_data #(
    parameter int IDX_W  = 4,
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                we_i,
    input  logic [IDX_W-1:0]    widx_i,
    input  logic [DATA_W/8-1:0] be_i,
    input  logic [DATA_W-1:0]   wdata_i,
    input  logic [IDX_W-1:0]    ridx_i,
    output logic [DATA_W-1:0]   rdata_o
);
    localparam int WORDS = 1 << IDX_W;
    localparam int BYTES = DATA_W / 8;

    logic [DATA_W-1:0] word_q [WORDS];

    always_ff @(posedge clk) begin
        if (we_i) begin
            for (int b = 0; b < BYTES; b++) begin
                if (be_i[b]) word_q[widx_i][b*8 +: 8] <= wdata_i[b*8 +: 8];
            end
        end
    end

    assign rdata_o = word_q[ridx_i];
endmodule

// File: rtl/sc_pick.sv
// Lowest-index set bit finder used to walk modified subblocks.
module sc_pick #(
    parameter int IDX_W = 2
) (
    input  logic [(1<<IDX_W)-1:0] vec_i,
    output logic                  any_o,
    output logic [IDX_W-1:0]      idx_o
);
    localparam int N = 1 << IDX_W;

    logic [N-1:0] below_clear;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_scan
            if (g == 0) begin : g_first
                assign below_clear[g] = 1'b1;
            end else begin : g_rest
                assign below_clear[g] = below_clear[g-1] & ~vec_i[g-1];
            end
        end
    endgenerate

    always_comb begin
        idx_o = '0;
        for (int i = 0; i < N; i++) begin
            if (vec_i[i] && below_clear[i]) idx_o = IDX_W'(i);
        end
    end

    assign any_o = |vec_i;
endmodule

// File: rtl/sect_wb_cache.sv
module sect_wb_cache
    import sc_pkg::*;
#(
    parameter int ADDR_W   = 10,
    parameter int DATA_W   = 32,
    parameter int SUB_BITS = 2,
    parameter int SET_BITS = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cpu_valid,
    output logic                cpu_ready,
    input  logic                cpu_we,
    input  logic [ADDR_W-1:0]   cpu_addr,
    input  logic [DATA_W/8-1:0] cpu_be,
    input  logic [DATA_W-1:0]   cpu_wdata,
    output logic                cpu_resp,
    output logic [DATA_W-1:0]   cpu_rdata,
    output logic                mem_req,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [DATA_W-1:0]   mem_wdata,
    input  logic                mem_ack,
    input  logic [DATA_W-1:0]   mem_rdata
);
    localparam int BE_W  = DATA_W / 8;
    localparam int TAG_W = ADDR_W - SUB_BITS - SET_BITS;
    localparam int SUBS  = 1 << SUB_BITS;
    localparam int IDX_W = SET_BITS + SUB_BITS;

    sc_state_e state_q, state_d;

    // latched request
    logic                req_we;
    logic [TAG_W-1:0]    req_tag;
    logic [SET_BITS-1:0] req_set;
    logic [SUB_BITS-1:0] req_sub;
    logic [BE_W-1:0]     req_be;
    logic [DATA_W-1:0]   req_wdata;

    // metadata and data store wiring
    logic [TAG_W-1:0]    line_tag;
    logic [SUBS-1:0]     line_valid;
    logic [SUBS-1:0]     line_dirty;
    logic [SUB_BITS-1:0] meta_sub;
    logic                m_alloc, m_set_valid, m_set_dirty, m_clr_dirty;
    logic                d_we;
    logic [BE_W-1:0]     d_be;
    logic [DATA_W-1:0]   d_wdata;
    logic [IDX_W-1:0]    d_ridx;
    logic [DATA_W-1:0]   d_rdata;
    logic                dirty_any;
    logic [SUB_BITS-1:0] dirty_idx;

    logic tag_eq, sub_hit, full_wr, finish;
    logic resp_q;
    logic [DATA_W-1:0] rdata_q;

    assign tag_eq  = (line_tag == req_tag);
    assign sub_hit = tag_eq && line_valid[req_sub];
    assign full_wr = req_we && (&req_be);
    assign finish  = (state_q == ST_LOOKUP) && tag_eq && (sub_hit || full_wr);

    sc_meta #(
        .SET_BITS (SET_BITS),
        .SUB_BITS (SUB_BITS),
        .TAG_W    (TAG_W)
    ) u_meta (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_i       (req_set),
        .sub_i       (meta_sub),
        .alloc_i     (m_alloc),
        .new_tag_i   (req_tag),
        .set_valid_i (m_set_valid),
        .set_dirty_i (m_set_dirty),
        .clr_dirty_i (m_clr_dirty),
        .tag_o       (line_tag),
        .valid_o     (line_valid),
        .dirty_o     (line_dirty)
    );

    sc_data #(
        .IDX_W  (IDX_W),
        .DATA_W (DATA_W)
    ) u_data (
        .clk     (clk),
        .we_i    (d_we),
        .widx_i  ({req_set, req_sub}),
        .be_i    (d_be),
        .wdata_i (d_wdata),
        .ridx_i  (d_ridx),
        .rdata_o (d_rdata)
    );

    sc_pick #(
        .IDX_W (SUB_BITS)
    ) u_pick (
        .vec_i (line_dirty),
        .any_o (dirty_any),
        .idx_o (dirty_idx)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // request capture on handshake
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_we    <= 1'b0;
            req_tag   <= '0;
            req_set   <= '0;
            req_sub   <= '0;
            req_be    <= '0;
            req_wdata <= '0;
        end else if (cpu_valid && cpu_ready) begin
            req_we    <= cpu_we;
            req_sub   <= cpu_addr[SUB_BITS-1:0];
            req_set   <= cpu_addr[SUB_BITS +: SET_BITS];
            req_tag   <= cpu_addr[ADDR_W-1 -: TAG_W];
            req_be    <= cpu_be;
            req_wdata <= cpu_wdata;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cpu_valid) state_d = ST_LOOKUP;
            end
            ST_LOOKUP: begin
                if (!tag_eq) begin
                    if (dirty_any) state_d = ST_WBACK;
                    else           state_d = ST_LOOKUP;
                end else if (sub_hit || full_wr) begin
                    state_d = ST_IDLE;
                end else begin
                    state_d = ST_FILL;
                end
            end
            ST_WBACK: begin
                if (!dirty_any) state_d = ST_LOOKUP;
            end
            ST_FILL: begin
                if (mem_ack) state_d = ST_LOOKUP;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs and datapath controls
    always_comb begin
        m_alloc     = 1'b0;
        m_set_valid = 1'b0;
        m_set_dirty = 1'b0;
        m_clr_dirty = 1'b0;
        meta_sub    = req_sub;
        d_we        = 1'b0;
        d_be        = '0;
        d_wdata     = req_wdata;
        d_ridx      = {req_set, req_sub};
        mem_req     = 1'b0;
        mem_we      = 1'b0;
        mem_addr    = {req_tag, req_set, req_sub};
        mem_wdata   = d_rdata;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_LOOKUP: begin
                if (!tag_eq && !dirty_any) begin
                    m_alloc = 1'b1;
                end else if (tag_eq && (sub_hit || full_wr) && req_we) begin
                    d_we        = 1'b1;
                    d_be        = req_be;
                    m_set_valid = 1'b1;
                    m_set_dirty = 1'b1;
                end
            end
            ST_WBACK: begin
                meta_sub = dirty_idx;
                d_ridx   = {req_set, dirty_idx};
                mem_req  = dirty_any;
                mem_we   = 1'b1;
                mem_addr = {line_tag, req_set, dirty_idx};
                if (mem_ack && dirty_any) m_clr_dirty = 1'b1;
            end
            ST_FILL: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    d_we        = 1'b1;
                    d_be        = '1;
                    d_wdata     = mem_rdata;
                    m_set_valid = 1'b1;
                end
            end
            default: begin
            end
        endcase
    end

    // response register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_q  <= 1'b0;
            rdata_q <= '0;
        end else begin
            resp_q <= finish;
            if (finish) rdata_q <= d_rdata;
        end
    end

    assign cpu_ready = (state_q == ST_IDLE);
    assign cpu_resp  = resp_q;
    assign cpu_rdata = rdata_q;

    AST_READY_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> !mem_req); // R11
    AST_RESP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_resp |=> !cpu_resp); // R11
    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R3
    AST_NO_FETCH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |-> !(req_we && (&req_be))); // R2
    AST_WB_ON_REPLACE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (line_tag != req_tag)); // R7
endmodule

// File: tb/sim_sect_wb_cache.sv
module sim_sect_wb_cache;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_valid = 1'b0;
    logic        cpu_ready;
    logic        cpu_we = 1'b0;
    logic [9:0]  cpu_addr = '0;
    logic [3:0]  cpu_be = '0;
    logic [31:0] cpu_wdata = '0;
    logic        cpu_resp;
    logic [31:0] cpu_rdata;
    logic        mem_req, mem_we, mem_ack;
    logic [9:0]  mem_addr;
    logic [31:0] mem_wdata, mem_rdata;

    int n_chk = 0;
    int n_fail = 0;
    int rd_cnt = 0;
    int wr_cnt = 0;
    int busy_ready = 0;

    always #5 clk = ~clk;

    sect_wb_cache u0 (
        .clk(clk), .rst_n(rst_n),
        .cpu_valid(cpu_valid), .cpu_ready(cpu_ready), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_be(cpu_be), .cpu_wdata(cpu_wdata),
        .cpu_resp(cpu_resp), .cpu_rdata(cpu_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    // behavioural next-level memory, fixed latency
    logic [31:0] mem_arr [1024];
    logic [1:0]  lat_cnt = '0;
    logic        ack_q = 1'b0;
    logic [31:0] rd_q = '0;
    assign mem_ack   = ack_q;
    assign mem_rdata = rd_q;

    initial for (int a = 0; a < 1024; a++) mem_arr[a] = 32'hA000_0000 | 32'(a);

    always @(posedge clk) begin
        if (ack_q) begin
            ack_q   <= 1'b0;
            lat_cnt <= '0;
        end else if (mem_req) begin
            if (lat_cnt == 2'd2) begin
                ack_q <= 1'b1;
                if (mem_we) begin
                    mem_arr[mem_addr] <= mem_wdata;
                    wr_cnt <= wr_cnt + 1;
                end else begin
                    rd_q   <= mem_arr[mem_addr];
                    rd_cnt <= rd_cnt + 1;
                end
            end else begin
                lat_cnt <= lat_cnt + 2'd1;
            end
        end
    end

    // R11 monitor: ready must be low while memory is busy
    always @(negedge clk) if (rst_n && mem_req && cpu_ready) busy_ready <= busy_ready + 1;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic [9:0] a, input logic [3:0] be,
                          input logic [31:0] wd, output logic [31:0] rd, output logic ok);
        int n;
        @(negedge clk);
        cpu_valid = 1'b1; cpu_we = we; cpu_addr = a; cpu_be = be; cpu_wdata = wd;
        @(negedge clk);
        cpu_valid = 1'b0;
        n = 0;
        while (!cpu_resp && n < 500) begin
            @(negedge clk);
            n++;
        end
        ok = cpu_resp;
        rd = cpu_rdata;
    endtask

    typedef struct packed {
        logic        we;
        logic [9:0]  addr;
        logic [3:0]  be;
        logic [31:0] wd;
        logic [31:0] exp;
        logic        cmp;
        logic [1:0]  nrd;
        logic [1:0]  nwr;
        logic [3:0]  req;
    } vec_t;

    // address: bits 1:0 subblock, 3:2 set, 9:4 tag
    localparam vec_t TBL [15] = '{
        '{1'b0, 10'h010, 4'h0, 32'h0,        32'hA000_0010, 1'b1, 2'd1, 2'd0, 4'd3},  // R3 read miss
        '{1'b0, 10'h010, 4'h0, 32'h0,        32'hA000_0010, 1'b1, 2'd0, 2'd0, 4'd1},  // R1 hit
        '{1'b1, 10'h011, 4'hF, 32'h1111_1111, 32'h0,        1'b0, 2'd0, 2'd0, 4'd2},  // R2 full write
        '{1'b0, 10'h011, 4'h0, 32'h0,        32'h1111_1111, 1'b1, 2'd0, 2'd0, 4'd2},  // R2 readback
        '{1'b1, 10'h012, 4'h3, 32'h0000_BEEF, 32'h0,        1'b0, 2'd1, 2'd0, 4'd9},  // R9 partial write
        '{1'b0, 10'h012, 4'h0, 32'h0,        32'hA000_BEEF, 1'b1, 2'd0, 2'd0, 4'd9},  // R9 merge
        '{1'b1, 10'h011, 4'hF, 32'h2222_2222, 32'h0,        1'b0, 2'd0, 2'd0, 4'd4},  // R4 no mem write
        '{1'b1, 10'h011, 4'hF, 32'h3333_3333, 32'h0,        1'b0, 2'd0, 2'd0, 4'd6},  // R6 rewrite
        '{1'b0, 10'h020, 4'h0, 32'h0,        32'hA000_0020, 1'b1, 2'd1, 2'd2, 4'd7},  // R7 evict dirty 1,2
        '{1'b0, 10'h021, 4'h0, 32'h0,        32'hA000_0021, 1'b1, 2'd1, 2'd0, 4'd8},  // R8 sub miss
        '{1'b0, 10'h020, 4'h0, 32'h0,        32'hA000_0020, 1'b1, 2'd0, 2'd0, 4'd8},  // R8 kept
        '{1'b0, 10'h010, 4'h0, 32'h0,        32'hA000_0010, 1'b1, 2'd1, 2'd0, 4'd10}, // R10 clean replace
        '{1'b0, 10'h011, 4'h0, 32'h0,        32'h3333_3333, 1'b1, 2'd1, 2'd0, 4'd10}, // R10 flags cleared
        '{1'b1, 10'h034, 4'hF, 32'h4444_4444, 32'h0,        1'b0, 2'd0, 2'd0, 4'd5},  // R5 write miss
        '{1'b0, 10'h034, 4'h0, 32'h0,        32'h4444_4444, 1'b1, 2'd0, 2'd0, 4'd5}   // R5 hit after
    };

    initial begin
        #(10 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic ok;
        int r0, w0;
        repeat (3) @(negedge clk);
        // R12 reset state
        chk("R12 ready", 32'(cpu_ready), 32'd1);
        chk("R12 mem_req", 32'(mem_req), 32'd0);
        chk("R12 resp", 32'(cpu_resp), 32'd0);
        rst_n = 1'b1;

        for (int i = 0; i < 15; i++) begin
            string tg;
            tg = $sformatf("R%0d vec%0d", TBL[i].req, i);
            r0 = rd_cnt; w0 = wr_cnt;
            access(TBL[i].we, TBL[i].addr, TBL[i].be, TBL[i].wd, rd, ok);
            chk({tg, " resp"}, 32'(ok), 32'd1);
            if (TBL[i].cmp) chk({tg, " data"}, rd, TBL[i].exp);
            chk({tg, " mem reads"}, 32'(rd_cnt - r0), 32'(TBL[i].nrd));
            chk({tg, " mem writes"}, 32'(wr_cnt - w0), 32'(TBL[i].nwr));
        end

        // R6/R7: one write-back per modified word, last value, clean word untouched
        chk("R6 final word", mem_arr[10'h011], 32'h3333_3333);
        chk("R9 merged word", mem_arr[10'h012], 32'hA000_BEEF);
        chk("R7 clean word", mem_arr[10'h010], 32'hA000_0010);
        chk("R6 total writes", 32'(wr_cnt), 32'd2);
        chk("R11 ready while busy", 32'(busy_ready), 32'd0);

        // R12: reset drops modified flags, so the stored word is refetched
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R12 ready after reset", 32'(cpu_ready), 32'd1);
        rst_n = 1'b1;
        r0 = rd_cnt; w0 = wr_cnt;
        access(1'b0, 10'h034, 4'h0, 32'h0, rd, ok);
        chk("R12 refetch data", rd, 32'hA000_0034);
        chk("R12 no write-back", 32'(wr_cnt - w0), 32'd0);
        chk("R12 one read", 32'(rd_cnt - r0), 32'd1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule